// File: doc/BRIEF.md
# Two-Port Word Memory with Same-Address Arbitration and Mailbox Interrupts

This block is a synchronous two-port word memory. Each side, A and B, has its own chip enable, write select, per-byte lane enables, address, write data and registered read data. Both sides may reach any word in the same clock cycle. When both are enabled on the same word, one side is allowed through and the other is told, on a busy pin that is plain combinational control and not a handshake, that it lost. A write from the losing side never reaches the array. The default depth is reduced for elaboration. Setting `AW=15` gives the full 32768-word by 16-bit arrangement.

The two highest word addresses can also act as mailboxes. A write by one side to its outgoing mailbox word raises an interrupt flag on the other side. A read of that word by the receiving side lowers the flag. The `irq_en` input chooses mailbox mode. With it low, both words are plain storage and the flags stay low. The interface has no valid/ready flow control. A request is taken in the cycle it is presented, and `x_rvalid` marks read data one cycle later. Back-pressure is given only by `x_busy`. A losing side may hold its request until busy drops.

Top module: `dpram_arb`

## Requirements
- R1: With x_ce=1 and x_we=0, the word at x_addr appears on x_rdata in the next cycle, with x_rvalid=1. x_rvalid is 0 after any cycle without such a read.
- R2: A write (x_ce=1, x_we=1) changes only the byte lanes whose enable is set: x_be[1] covers bits 15:8 and x_be[0] covers bits 7:0.
- R3: x_busy is raised only while both chip enables are 1 and both addresses are equal. At most one of a_busy and b_busy is 1 in any cycle.
- R4: If a collision begins with neither side holding that word in the previous cycle, or with both sides doing so, side A wins and b_busy=1. If only one side was enabled on that word in the previous cycle, that side wins. The winner does not change while the collision continues on the same word.
- R5: A write from the side whose busy is 1 leaves the array unchanged. A read that collides with a write from the other side returns the word as it was before that write.
- R6: With irq_en=1, a successful write by A to the top word (all address bits 1) sets b_irq in the next cycle. A read of that word by B clears b_irq in the next cycle. If a set and a clear occur in the same cycle, the set wins.
- R7: With irq_en=1, a successful write by B to the word one below the top sets a_irq in the next cycle. A read of that word by A clears a_irq. If a set and a clear occur in the same cycle, the set wins.
- R8: With irq_en=0, both irq flags are 0 in the next cycle and stay 0. The two mailbox words store and return data like any other word.
- R9: After reset, a_irq, b_irq, a_rvalid and b_rvalid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Mailbox interrupt mode enable |
| a_ce | input | 1 | Side A chip enable |
| a_we | input | 1 | Side A write select (1 = write) |
| a_be | input | 2 | Side A byte lane enables |
| a_addr | input | AW | Side A word address |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data |
| a_rvalid | output | 1 | Side A read data valid |
| a_busy | output | 1 | Side A lost arbitration this cycle |
| a_irq | output | 1 | Interrupt toward side A |
| b_ce | input | 1 | Side B chip enable |
| b_we | input | 1 | Side B write select (1 = write) |
| b_be | input | 2 | Side B byte lane enables |
| b_addr | input | AW | Side B word address |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data |
| b_rvalid | output | 1 | Side B read data valid |
| b_busy | output | 1 | Side B lost arbitration this cycle |
| b_irq | output | 1 | Interrupt toward side A's partner, side B |

## Verification
The hardest case to reach is a collision in which B already held the word and A arrives later, so that A must lose. Pure random traffic seldom builds that order and then holds it. The bench drives it on purpose: B alone for one cycle, then both sides on that word over several cycles, with A attempting a write that must be dropped. Random traffic is then confined to eight words that include both mailbox words, so that collisions and mailbox set/clear races occur often.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;
endpackage

// File: rtl/dpram_arbiter.sv
module dpram_arbiter #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_ce,
  input  logic [AW-1:0] a_addr,
  input  logic          b_ce,
  input  logic [AW-1:0] b_addr,
  output logic          a_busy,
  output logic          b_busy
);
  import dpram_pkg::*;

  logic          pa_on, pb_on, p_coll;
  logic [AW-1:0] pa_addr, pb_addr, p_caddr;
  side_e         p_win;

  logic  coll, keep, b_first, a_first;
  side_e win;

  always_comb begin
    coll    = a_ce && b_ce && (a_addr == b_addr);
    keep    = p_coll && (p_caddr == a_addr);
    b_first = pb_on && (pb_addr == b_addr);
    a_first = pa_on && (pa_addr == a_addr);
    if (keep)                    win = p_win;
    else if (b_first && !a_first) win = SIDE_B;
    else                          win = SIDE_A;
    a_busy = coll && (win == SIDE_B);
    b_busy = coll && (win == SIDE_A);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_on   <= 1'b0;
      pb_on   <= 1'b0;
      p_coll  <= 1'b0;
      pa_addr <= '0;
      pb_addr <= '0;
      p_caddr <= '0;
      p_win   <= SIDE_A;
    end else begin
      pa_on   <= a_ce;
      pb_on   <= b_ce;
      pa_addr <= a_addr;
      pb_addr <= b_addr;
      p_coll  <= coll;
      p_caddr <= a_addr;
      p_win   <= win;
    end
  end
endmodule

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_wen,
  input  logic                a_ren,
  input  logic [DW/LW-1:0]    a_be,
  input  logic [AW-1:0]       a_addr,
  input  logic [DW-1:0]       a_wdata,
  output logic [DW-1:0]       a_rdata,
  output logic                a_rvalid,
  input  logic                b_wen,
  input  logic                b_ren,
  input  logic [DW/LW-1:0]    b_be,
  input  logic [AW-1:0]       b_addr,
  input  logic [DW-1:0]       b_wdata,
  output logic [DW-1:0]       b_rdata,
  output logic                b_rvalid
);
  localparam int DEPTH = 1 << AW;
  localparam int LANES = DW / LW;

  logic [DW-1:0] mem [DEPTH];

  // The arbiter guarantees the two write ports never target one word together.
  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (a_wen && a_be[l]) mem[a_addr][l*LW +: LW] <= a_wdata[l*LW +: LW];
      if (b_wen && b_be[l]) mem[b_addr][l*LW +: LW] <= b_wdata[l*LW +: LW];
    end
    if (a_ren) a_rdata <= mem[a_addr];
    if (b_ren) b_rdata <= mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rvalid <= 1'b0;
      b_rvalid <= 1'b0;
    end else begin
      a_rvalid <= a_ren;
      b_rvalid <= b_ren;
    end
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox #(
  parameter int AW = 10,
  parameter logic [AW-1:0] SLOT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_go,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic          flag
);
  logic set_hit, clr_hit;

  always_comb begin
    set_hit = wr_go && (wr_addr == SLOT);
    clr_hit = rd_go && (rd_addr == SLOT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (!en)     flag <= 1'b0;
    else if (set_hit) flag <= 1'b1;
    else if (clr_hit) flag <= 1'b0;
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_en,
  input  logic                a_ce,
  input  logic                a_we,
  input  logic [DW/LW-1:0]    a_be,
  input  logic [AW-1:0]       a_addr,
  input  logic [DW-1:0]       a_wdata,
  output logic [DW-1:0]       a_rdata,
  output logic                a_rvalid,
  output logic                a_busy,
  output logic                a_irq,
  input  logic                b_ce,
  input  logic                b_we,
  input  logic [DW/LW-1:0]    b_be,
  input  logic [AW-1:0]       b_addr,
  input  logic [DW-1:0]       b_wdata,
  output logic [DW-1:0]       b_rdata,
  output logic                b_rvalid,
  output logic                b_busy,
  output logic                b_irq
);
  localparam logic [AW-1:0] SLOT_TO_B = '1;
  localparam logic [AW-1:0] SLOT_TO_A = SLOT_TO_B - 1'b1;

  logic a_wen, b_wen, a_ren, b_ren;

  dpram_arbiter #(.AW(AW)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .a_ce(a_ce), .a_addr(a_addr),
    .b_ce(b_ce), .b_addr(b_addr),
    .a_busy(a_busy), .b_busy(b_busy)
  );

  always_comb begin
    a_wen = a_ce && a_we && !a_busy;
    b_wen = b_ce && b_we && !b_busy;
    a_ren = a_ce && !a_we;
    b_ren = b_ce && !b_we;
  end

  dpram_store #(.AW(AW), .DW(DW), .LW(LW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_wen(a_wen), .a_ren(a_ren), .a_be(a_be), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_wen(b_wen), .b_ren(b_ren), .b_be(b_be), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  dpram_mailbox #(.AW(AW), .SLOT(SLOT_TO_B)) u_mbox_to_b (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .wr_go(a_wen), .wr_addr(a_addr),
    .rd_go(b_ren), .rd_addr(b_addr),
    .flag(b_irq)
  );

  dpram_mailbox #(.AW(AW), .SLOT(SLOT_TO_A)) u_mbox_to_a (
    .clk(clk), .rst_n(rst_n), .en(irq_en),
    .wr_go(b_wen), .wr_addr(b_addr),
    .rd_go(a_ren), .rd_addr(a_addr),
    .flag(a_irq)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int AW = 10,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_en,
  input logic             a_ce,
  input logic             a_we,
  input logic [DW/LW-1:0] a_be,
  input logic [AW-1:0]    a_addr,
  input logic [DW-1:0]    a_wdata,
  input logic [DW-1:0]    a_rdata,
  input logic             a_rvalid,
  input logic             a_busy,
  input logic             a_irq,
  input logic             b_ce,
  input logic             b_we,
  input logic [DW/LW-1:0] b_be,
  input logic [AW-1:0]    b_addr,
  input logic [DW-1:0]    b_wdata,
  input logic [DW-1:0]    b_rdata,
  input logic             b_rvalid,
  input logic             b_busy,
  input logic             b_irq
);
  localparam logic [AW-1:0] TOPW = '1;
  localparam logic [AW-1:0] NEXTW = TOPW - 1'b1;

  logic started;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_busy && b_busy)); // R3
  AST_BUSY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (a_busy || b_busy) |-> (a_ce && b_ce && a_addr == b_addr)); // R3
  AST_TIE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (started && a_ce && b_ce && a_addr == b_addr && !$past(a_ce) && !$past(b_ce)) |-> b_busy); // R4
  AST_IRQ_B_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && a_ce && a_we && !a_busy && a_addr == TOPW) |=> b_irq); // R6
  AST_IRQ_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && b_ce && b_we && !b_busy && b_addr == NEXTW) |=> a_irq); // R7
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (!a_irq && !b_irq)); // R8
  AST_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ce && !a_we) |=> a_rvalid); // R1
endmodule

bind dpram_arb dpram_arb_chk #(.AW(AW), .DW(DW), .LW(LW)) u_chk (.*);

// File: tb/dpram_arb_tb.sv
module dpram_arb_tb;
  localparam int PERIOD = 10;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOPW = '1;
  localparam logic [AW-1:0] NEXTW = TOPW - 1'b1;

  logic clk = 1'b0, rst_n = 1'b0, irq_en = 1'b0;
  logic a_ce = 0, a_we = 0, b_ce = 0, b_we = 0;
  logic [1:0] a_be = 0, b_be = 0;
  logic [AW-1:0] a_addr = 0, b_addr = 0;
  logic [15:0] a_wdata = 0, b_wdata = 0;
  logic [15:0] a_rdata, b_rdata;
  logic a_rvalid, b_rvalid, a_busy, b_busy, a_irq, b_irq;

  always #(PERIOD/2) clk = ~clk;

  dpram_arb #(.AW(AW)) u_dut (.*);

  int errors = 0, checks = 0;
  logic [15:0] ref_mem [DEPTH];
  // model state
  bit m_pa_on, m_pb_on, m_coll, m_winb;
  int m_pa, m_pb, m_caddr;
  bit e_arv, e_brv, e_airq, e_birq;
  logic [15:0] e_ard, e_brd;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] be);
    merge = old;
    if (be[0]) merge[7:0] = nw[7:0];
    if (be[1]) merge[15:8] = nw[15:8];
  endfunction

  task automatic step(input string tag,
                      input bit ace, input bit awe, input logic [1:0] abe, input int aad, input logic [15:0] awd,
                      input bit bce, input bit bwe, input logic [1:0] bbe, input int bad, input logic [15:0] bwd);
    bit match, winb, eab, ebb, aw_ok, bw_ok;
    a_ce = ace; a_we = awe; a_be = abe; a_addr = AW'(aad); a_wdata = awd;
    b_ce = bce; b_we = bwe; b_be = bbe; b_addr = AW'(bad); b_wdata = bwd;
    match = ace && bce && (aad == bad);
    if (!match) winb = 0;
    else if (m_coll && m_caddr == aad) winb = m_winb;
    else winb = (m_pb_on && m_pb == bad) && !(m_pa_on && m_pa == aad);
    eab = match && winb;
    ebb = match && !winb;
    #1;
    chk(tag, "a_busy", a_busy, eab);
    chk(tag, "b_busy", b_busy, ebb);
    @(posedge clk);
    e_arv = ace && !awe; e_brv = bce && !bwe;
    if (e_arv) e_ard = ref_mem[aad];
    if (e_brv) e_brd = ref_mem[bad];
    aw_ok = ace && awe && !eab;
    bw_ok = bce && bwe && !ebb;
    if (aw_ok) ref_mem[aad] = merge(ref_mem[aad], awd, abe);
    if (bw_ok) ref_mem[bad] = merge(ref_mem[bad], bwd, bbe);
    if (!irq_en) begin e_airq = 0; e_birq = 0; end
    else begin
      if (aw_ok && aad == int'(TOPW)) e_birq = 1;
      else if (e_brv && bad == int'(TOPW)) e_birq = 0;
      if (bw_ok && bad == int'(NEXTW)) e_airq = 1;
      else if (e_arv && aad == int'(NEXTW)) e_airq = 0;
    end
    m_pa_on = ace; m_pb_on = bce; m_pa = aad; m_pb = bad;
    m_coll = match; m_caddr = aad; m_winb = winb;
    @(negedge clk);
    chk(tag, "a_rvalid", a_rvalid, e_arv);
    chk(tag, "b_rvalid", b_rvalid, e_brv);
    if (e_arv) chk(tag, "a_rdata", a_rdata, e_ard);
    if (e_brv) chk(tag, "b_rdata", b_rdata, e_brd);
    chk(tag, "a_irq", a_irq, e_airq);
    chk(tag, "b_irq", b_irq, e_birq);
  endtask

  task automatic idle(input string tag);
    step(tag, 0,0,2'b00,0,16'h0, 0,0,2'b00,0,16'h0);
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "a_irq", a_irq, 0);
    chk("R9", "b_irq", b_irq, 0);
    chk("R9", "a_rvalid", a_rvalid, 0);
    chk("R9", "b_rvalid", b_rvalid, 0);
    rst_n = 1'b1;
    // fill: A writes even words, B odd words
    for (int i = 0; i < DEPTH; i += 2) begin
      ref_mem[i] = 16'(i * 37 + 5);
      ref_mem[i+1] = 16'(i * 91 + 3);
      step("R1", 1,1,2'b11,i,16'(i*37+5), 1,1,2'b11,i+1,16'(i*91+3));
    end
    step("R1", 1,0,2'b00,10,16'h0, 1,0,2'b00,11,16'h0);
    // R2 byte lanes
    step("R2", 1,1,2'b10,20,16'hAB00, 1,1,2'b01,21,16'h00CD);
    step("R2", 1,0,2'b00,21,16'h0, 1,0,2'b00,20,16'h0);
    step("R2", 1,1,2'b00,22,16'hFFFF, 0,0,2'b00,0,16'h0);
    step("R2", 1,0,2'b00,22,16'h0, 0,0,2'b00,0,16'h0);
    // R4 tie: both start together, A wins, B write dropped (R5)
    idle("R4");
    step("R4", 1,1,2'b11,30,16'h1111, 1,1,2'b11,30,16'h2222);
    step("R5", 1,0,2'b00,30,16'h0, 0,0,2'b00,0,16'h0);
    // R4 B holds first, A arrives late and loses; A write dropped (R5)
    idle("R4");
    step("R4", 0,0,2'b00,0,16'h0, 1,0,2'b00,40,16'h0);
    step("R4", 1,1,2'b11,40,16'hDEAD, 1,0,2'b00,40,16'h0);
    step("R5", 1,1,2'b11,40,16'hBEEF, 1,1,2'b01,40,16'h0077);
    step("R4", 1,1,2'b11,40,16'hCAFE, 1,0,2'b00,40,16'h0);
    step("R5", 0,0,2'b00,0,16'h0, 1,0,2'b00,40,16'h0);
    // R5 read collides with winning write: old data
    idle("R5");
    step("R5", 1,1,2'b11,50,16'h5A5A, 1,0,2'b00,50,16'h0);
    step("R5", 0,0,2'b00,0,16'h0, 1,0,2'b00,50,16'h0);
    // R3 different addresses: no busy
    step("R3", 1,1,2'b11,60,16'h0606, 1,1,2'b11,61,16'h0616);
    // mailboxes
    irq_en = 1'b1;
    idle("R6");
    step("R6", 1,1,2'b11,int'(TOPW),16'h1234, 0,0,2'b00,0,16'h0);
    step("R6", 0,0,2'b00,0,16'h0, 1,0,2'b00,int'(TOPW),16'h0);
    step("R7", 0,0,2'b00,0,16'h0, 1,1,2'b11,int'(NEXTW),16'h4321);
    step("R7", 1,0,2'b00,int'(NEXTW),16'h0, 0,0,2'b00,0,16'h0);
    // set and clear race: B read of top and A write elsewhere-then-same
    step("R6", 1,1,2'b11,int'(TOPW),16'h7777, 0,0,2'b00,0,16'h0);
    idle("R6");
    step("R6", 1,1,2'b11,int'(TOPW),16'h8888, 1,0,2'b00,int'(TOPW),16'h0);
    step("R6", 0,0,2'b00,0,16'h0, 1,0,2'b00,int'(TOPW),16'h0);
    // R8 disabled: plain storage, flags low
    step("R7", 0,0,2'b00,0,16'h0, 1,1,2'b11,int'(NEXTW),16'h9999);
    irq_en = 1'b0;
    step("R8", 1,1,2'b11,int'(TOPW),16'h3C3C, 0,0,2'b00,0,16'h0);
    step("R8", 1,0,2'b00,int'(NEXTW),16'h0, 1,0,2'b00,int'(TOPW),16'h0);
    // random traffic on eight words including mailboxes
    for (int n = 0; n < 3000; n++) begin
      bit ace, awe, bce, bwe;
      int aad, bad;
      if (n % 500 == 0) irq_en = ~irq_en;
      ace = ($urandom % 4) != 0; bce = ($urandom % 4) != 0;
      awe = $urandom % 2; bwe = $urandom % 2;
      aad = int'(TOPW) - int'($urandom % 8);
      bad = int'(TOPW) - int'($urandom % 8);
      step("R1", ace, awe, 2'($urandom), aad, 16'($urandom),
                 bce, bwe, 2'($urandom), bad, 16'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule